// File: doc/BRIEF.md
# Transmit Descriptor Control-Word Sequencer

This block walks one transmit descriptor through its control-word life cycle. When started with a descriptor base address, it fetches the 32-bit frame control word from descriptor memory and pushes that word into the transmit FIFO. It then starts the fragment DMA engine and waits for it to report that every fragment has moved. After that it fetches the control word again and writes it back with the DMA-done flag set. The interrupt decision uses the second fetch, so host software can still change its mind about the DMA-complete interrupt while the fragments are in flight.

For each frame it pushes, the block keeps a small in-order record of the transmit-indicate flag and the frame identifier. When the transmitter reports that a frame has left the medium, the oldest record is retired. If its flag was set, a transmit-complete interrupt pulse is raised together with that frame's identifier. The two interrupt pulses are independent and may occur in the same cycle.

Top module: `txdesc_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, memory request, FIFO write, fragment start and both interrupt outputs are 0.
- R2: After an accepted start, the first memory access is a read at the descriptor base plus the control offset (default 4). The request stays asserted with a stable address until acknowledged.
- R3: The word returned by the first read is written to the FIFO exactly once, as a one-cycle write. No write occurs while the FIFO full input is high.
- R4: A one-cycle fragment start pulse follows the FIFO write, and never comes before it. The block then waits for fragment done.
- R5: After fragment done, the control word is read a second time from the same address.
- R6: The write-back goes to the same address and carries the second-read value with bit 16 set. All other bits are unchanged.
- R7: A one-cycle DMA-complete interrupt is raised in the cycle after the write-back is acknowledged, if and only if bit 31 of the second read is 1.
- R8: On a transmitter done pulse, the oldest pending frame is retired. If bit 15 of its first read was 1, a one-cycle transmit-complete interrupt is raised in the next cycle, with bits 9:2 of that word on the ID output.
- R9: A start request while busy is ignored. It causes no memory access and does not change the descriptor being processed.
- R10: Busy stays high from an accepted start until the write-back acknowledge, and drops in the next cycle.
- R11: The pending-frame record holds a parameterized number of frames (default 4). When it is full, the FIFO write stalls until a frame is retired. A transmitter done pulse with no pending frame raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin processing a descriptor |
| desc_base_i | input | AW | Descriptor base address |
| busy_o | output | 1 | A descriptor is in progress |
| mem_req_o | output | 1 | Memory access request, held until acknowledge |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory access acknowledge |
| fifo_full_i | input | 1 | Transmit FIFO cannot take a word |
| fifo_wr_o | output | 1 | Transmit FIFO write strobe |
| fifo_data_o | output | 32 | Control word into the FIFO |
| frag_start_o | output | 1 | Start fragment DMA (pulse) |
| frag_done_i | input | 1 | All fragments transferred (pulse) |
| tx_done_i | input | 1 | A frame finished on the medium (pulse) |
| dma_irq_o | output | 1 | DMA-complete interrupt pulse |
| tx_irq_o | output | 1 | Transmit-complete interrupt pulse |
| tx_irq_id_o | output | 8 | Frame ID for the transmit-complete interrupt |

## Verification
The DMA-complete and transmit-complete interrupts can land in the same cycle. This happens when the transmitter retires an earlier frame at the very edge that acknowledges the current descriptor's write-back. The bench provokes this from its memory model: on the write acknowledge it also pulses transmitter done, with a pending flagged frame and bit 31 set in the current word. It then checks that both pulses appear together in the next cycle and that the ID belongs to the older frame. Sweeps over the flag combinations, a host-side flip of bit 31 during fragment transfer, FIFO back-pressure and a full pending record cover the rest.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  localparam int CW          = 32;
  localparam int BIT_DMA_IND = 31;
  localparam int BIT_DMA_DON = 16;
  localparam int BIT_TX_IND  = 15;
  localparam int ID_LSB      = 2;
  localparam int ID_W        = 8;

  typedef struct packed {
    logic            ind;
    logic [ID_W-1:0] id;
  } tag_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_PUSH, S_FRAG_GO, S_FRAG_WAIT, S_RD2, S_WB
  } st_t;
endpackage

// File: rtl/txdesc_fsm.sv
module txdesc_fsm
  import txdesc_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CTL_OFS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [CW-1:0] mem_wdata_o,
  input  logic [CW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          fifo_full_i,
  output logic          fifo_wr_o,
  output logic [CW-1:0] fifo_data_o,
  output logic          frag_start_o,
  input  logic          frag_done_i,
  input  logic          tagq_full_i,
  output logic          push_o,
  output tag_t          push_tag_o,
  output logic          dma_fire_o
);
  localparam logic [AW-1:0] OFS      = AW'(CTL_OFS);
  localparam logic [CW-1:0] DON_MASK = CW'(1) << BIT_DMA_DON;

  st_t           st;
  logic [CW-1:0] word1;
  logic          ind2;
  logic [AW-1:0] ctl_addr;

  assign push_o     = (st == S_PUSH) && !fifo_full_i && !tagq_full_i;
  assign dma_fire_o = (st == S_WB) && mem_ack_i && ind2;
  assign busy_o     = (st != S_IDLE);

  always_comb begin
    push_tag_o.ind = word1[BIT_TX_IND];
    push_tag_o.id  = word1[ID_LSB +: ID_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      mem_req_o    <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      fifo_wr_o    <= 1'b0;
      fifo_data_o  <= '0;
      frag_start_o <= 1'b0;
      word1        <= '0;
      ind2         <= 1'b0;
      ctl_addr     <= '0;
    end else begin
      fifo_wr_o    <= 1'b0;
      frag_start_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          ctl_addr   <= base_i + OFS;
          mem_addr_o <= base_i + OFS;
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          st         <= S_RD1;
        end
        S_RD1: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          word1     <= mem_rdata_i;
          st        <= S_PUSH;
        end
        S_PUSH: if (push_o) begin
          fifo_wr_o   <= 1'b1;
          fifo_data_o <= word1;
          st          <= S_FRAG_GO;
        end
        S_FRAG_GO: begin
          frag_start_o <= 1'b1;
          st           <= S_FRAG_WAIT;
        end
        S_FRAG_WAIT: if (frag_done_i) begin
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          mem_addr_o <= ctl_addr;
          st         <= S_RD2;
        end
        S_RD2: if (mem_ack_i) begin
          ind2        <= mem_rdata_i[BIT_DMA_IND];
          mem_wdata_o <= mem_rdata_i | DON_MASK;
          mem_we_o    <= 1'b1;
          st          <= S_WB;
        end
        S_WB: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          mem_we_o  <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: request held steady until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R3: FIFO write is a single-cycle strobe
  p_fifo_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |=> !fifo_wr_o);
  // R4: fragment start follows the FIFO write
  p_frag_after_fifo_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(frag_start_o) |-> $past(fifo_wr_o));
  // R6: every write-back carries the done flag
  p_wb_done_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[BIT_DMA_DON]);
  // R10: busy drops only after the write-back acknowledge
  p_busy_until_wb_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(mem_ack_i && mem_we_o));
endmodule

// File: rtl/txdesc_tagq.sv
module txdesc_tagq
  import txdesc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  tag_t push_tag_i,
  input  logic pop_i,
  output logic full_o,
  output logic pop_ok_o,
  output tag_t head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   CAP  = (PW + 1)'(DEPTH);

  tag_t          slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          empty;

  assign empty    = (cnt == '0);
  assign full_o   = (cnt == CAP);
  assign pop_ok_o = pop_i && !empty;
  assign head_o   = slots[rp];

  always_ff @(posedge clk) begin
    if (push_i) slots[wp] <= push_tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i)   wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok_o) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_i, pop_ok_o})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R11: no push into a full record, count stays in range
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  p_count_range_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);
endmodule

// File: rtl/txdesc_irq.sv
module txdesc_irq
  import txdesc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            dma_fire_i,
  input  logic            pop_ok_i,
  input  tag_t            head_i,
  output logic            dma_irq_o,
  output logic            tx_irq_o,
  output logic [ID_W-1:0] tx_id_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_irq_o <= 1'b0;
      tx_irq_o  <= 1'b0;
      tx_id_o   <= '0;
    end else begin
      dma_irq_o <= dma_fire_i;
      tx_irq_o  <= pop_ok_i && head_i.ind;
      if (pop_ok_i) tx_id_o <= head_i.id;
    end
  end

  // R7: DMA interrupt is a single-cycle pulse
  p_dma_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    dma_irq_o |=> !dma_irq_o);
  // R8: transmit interrupt only after a retired frame
  p_tx_src_r8: assert property (@(posedge clk) disable iff (rst)
    tx_irq_o |-> $past(pop_ok_i));
endmodule

// File: rtl/txdesc_ctl.sv
module txdesc_ctl
  import txdesc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CTL_OFS   = 4,
  parameter int TAG_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [AW-1:0]   desc_base_i,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [CW-1:0]   mem_wdata_o,
  input  logic [CW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  input  logic            fifo_full_i,
  output logic            fifo_wr_o,
  output logic [CW-1:0]   fifo_data_o,
  output logic            frag_start_o,
  input  logic            frag_done_i,
  input  logic            tx_done_i,
  output logic            dma_irq_o,
  output logic            tx_irq_o,
  output logic [ID_W-1:0] tx_irq_id_o
);
  logic tq_full, push, pop_ok, dma_fire;
  tag_t push_tag, head;

  txdesc_fsm #(.AW(AW), .CTL_OFS(CTL_OFS)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(desc_base_i), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o),
    .frag_start_o(frag_start_o), .frag_done_i(frag_done_i), .tagq_full_i(tq_full),
    .push_o(push), .push_tag_o(push_tag), .dma_fire_o(dma_fire)
  );

  txdesc_tagq #(.DEPTH(TAG_DEPTH)) u_tagq (
    .clk(clk), .rst(rst), .push_i(push), .push_tag_i(push_tag), .pop_i(tx_done_i),
    .full_o(tq_full), .pop_ok_o(pop_ok), .head_o(head)
  );

  txdesc_irq u_irq (
    .clk(clk), .rst(rst), .dma_fire_i(dma_fire), .pop_ok_i(pop_ok), .head_i(head),
    .dma_irq_o(dma_irq_o), .tx_irq_o(tx_irq_o), .tx_id_o(tx_irq_id_o)
  );
endmodule

// File: tb/tb_txdesc_ctl.sv
module tb_txdesc_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic busy, mem_req, mem_we, mem_ack, fifo_full, fifo_wr, frag_start, frag_done;
  logic tx_q, coin_p, tx_done, dma_irq, tx_irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, fifo_data;
  logic [7:0] tx_id;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tx_done = tx_q | coin_p;

  txdesc_ctl #(.AW(AW), .CTL_OFS(4), .TAG_DEPTH(4)) dut (
    .clk(clk), .rst(rst), .start_i(start), .desc_base_i(base_in), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .fifo_full_i(fifo_full), .fifo_wr_o(fifo_wr),
    .fifo_data_o(fifo_data), .frag_start_o(frag_start), .frag_done_i(frag_done),
    .tx_done_i(tx_done), .dma_irq_o(dma_irq), .tx_irq_o(tx_irq), .tx_irq_id_o(tx_id)
  );

  // memory model and monitor (sole owner of these variables)
  logic [31:0] mem [64];
  int n_rd = 0, n_wb = 0, n_fifo = 0, n_frag = 0, n_dma = 0, n_tx = 0, n_both = 0;
  logic [AW-1:0] rd_last = '0, wb_addr = '0;
  logic [31:0] last_fifo = '0;
  logic [7:0] last_tx_id = '0;
  logic busy_at_wb = 1'b0;
  logic hw_en = 1'b0, coin_arm = 1'b0;
  logic [5:0] hw_idx = '0;
  logic [31:0] hw_val = '0;

  initial begin
    mem_ack = 1'b0; mem_rdata = '0; coin_p = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    if (coin_p) coin_p = 1'b0;
    if (hw_en) mem[hw_idx] = hw_val;
    if (fifo_wr) begin n_fifo++; last_fifo = fifo_data; end
    if (frag_start) n_frag++;
    if (dma_irq) n_dma++;
    if (tx_irq) begin n_tx++; last_tx_id = tx_id; end
    if (dma_irq && tx_irq) n_both++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata; n_wb++; wb_addr = mem_addr; busy_at_wb = busy;
        if (coin_arm) coin_p = 1'b1;
      end else begin
        mem_rdata = mem[mem_addr[7:2]]; n_rd++; rd_last = mem_addr;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [8:0] eq [32];
  int eh = 0, et = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", rq, act, exp); end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic host_wr(input logic [5:0] idx, input logic [31:0] val);
    hw_en = 1'b1; hw_idx = idx; hw_val = val; tick(); hw_en = 1'b0;
  endtask

  task automatic tx_pop(input string rq);
    bit have;
    logic [8:0] h;
    have = (et > eh);
    h = have ? eq[eh % 32] : 9'd0;
    tx_q = 1'b1; tick(); tx_q = 1'b0;
    if (have) eh++;
    chk(tx_irq == (have && h[8]), rq, {31'd0, tx_irq}, {31'd0, have && h[8]});
    if (have && h[8]) chk(tx_id == h[7:0], {rq, " id"}, {24'd0, tx_id}, {24'd0, h[7:0]});
  endtask

  task automatic run_desc(input logic [7:0] base, input logic [31:0] ctl,
                          input bit flip, input bit coin, input bit hold);
    int r0, f0, g0, d0, w0, b0;
    logic [31:0] expw;
    r0 = n_rd; f0 = n_fifo; g0 = n_frag; d0 = n_dma; w0 = n_wb; b0 = n_both;
    host_wr(base[7:2] + 6'd1, ctl);
    fifo_full = hold;
    start = 1'b1; base_in = base; tick(); start = 1'b0;
    if (hold) begin
      repeat (6) tick();
      chk(n_fifo == f0 && busy, "R3 stall while full", n_fifo - f0, 0);
      fifo_full = 1'b0;
    end
    for (int i = 0; i < 60 && n_frag == g0; i++) tick();
    chk(n_frag == g0 + 1, "R4 fragment start", n_frag - g0, 1);
    chk(rd_last == base + 8'd4, "R2 first read addr", {24'd0, rd_last}, {24'd0, base + 8'd4});
    chk(n_fifo == f0 + 1 && last_fifo == ctl, "R3 fifo word", last_fifo, ctl);
    eq[et % 32] = {ctl[15], ctl[9:2]}; et++;
    start = 1'b1; base_in = 8'd200; tick(); start = 1'b0;
    if (flip) host_wr(base[7:2] + 6'd1, mem[base[7:2] + 6'd1] ^ 32'h8000_0000);
    repeat (3) tick();
    chk(n_rd == r0 + 1 && busy && n_frag == g0 + 1, "R9 start ignored", n_rd - r0, 1);
    coin_arm = coin; frag_done = 1'b1; tick(); frag_done = 1'b0;
    for (int i = 0; i < 60 && busy; i++) tick();
    coin_arm = 1'b0;
    expw = (ctl ^ (flip ? 32'h8000_0000 : 32'h0)) | 32'h0001_0000;
    chk(n_rd == r0 + 2 && rd_last == base + 8'd4, "R5 second read", n_rd - r0, 2);
    chk(n_wb == w0 + 1 && wb_addr == base + 8'd4 && mem[base[7:2] + 6'd1] == expw,
        "R6 write-back", mem[base[7:2] + 6'd1], expw);
    chk(n_dma == d0 + int'(expw[31]), "R7 dma irq", n_dma - d0, {31'd0, expw[31]});
    chk(busy_at_wb && !busy, "R10 busy until write-back", {31'd0, busy}, 0);
    if (coin) begin
      chk(n_both == b0 + 1, "R7 R8 coincident pulses", n_both - b0, 1);
      chk(last_tx_id == eq[eh % 32][7:0], "R8 coincident id", {24'd0, last_tx_id},
          {24'd0, eq[eh % 32][7:0]});
      eh++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int f0, r0, g0;
    fifo_full = 1'b0; frag_done = 1'b0; tx_q = 1'b0;
    repeat (3) tick();
    chk(!busy && !mem_req && !fifo_wr && !frag_start && !dma_irq && !tx_irq,
        "R1 reset state", {26'd0, busy, mem_req, fifo_wr, frag_start, dma_irq, tx_irq}, 0);
    rst = 1'b0; tick();
    chk(!busy && !mem_req && !dma_irq && !tx_irq, "R1 after reset",
        {28'd0, busy, mem_req, dma_irq, tx_irq}, 0);

    // sweep over indicate flags, host flip of bit 31 and FIFO back-pressure
    for (int k = 0; k < 8; k++) begin
      logic [31:0] c;
      c = ({31'd0, k[0]} << 31) | ({31'd0, k[1]} << 15)
        | ({24'd0, 8'((k * 37 + 5) & 255)} << 2) | (32'(k) << 20);
      run_desc(8'(k * 8), c, k[2], 1'b0, k == 3);
      tx_pop("R8 tx irq sweep");
    end
    tx_pop("R11 done with nothing pending");

    // coincident interrupts
    run_desc(8'd0, 32'h0000_8000 | (32'h5A << 2), 1'b0, 1'b0, 1'b0);
    run_desc(8'd8, 32'h8000_8000 | (32'h33 << 2), 1'b0, 1'b1, 1'b0);
    tx_pop("R8 after coincidence");

    // full pending record
    for (int j = 0; j < 4; j++)
      run_desc(8'(16 + j * 8), 32'h0000_8000 | (32'(8'h10 + j) << 2), 1'b0, 1'b0, 1'b0);
    host_wr(6'd13, 32'h0000_8000 | (32'h77 << 2));
    f0 = n_fifo; r0 = n_rd; g0 = n_frag;
    start = 1'b1; base_in = 8'd48; tick(); start = 1'b0;
    repeat (8) tick();
    chk(n_fifo == f0 && n_frag == g0 && n_rd == r0 + 1 && busy, "R11 full record stalls",
        n_fifo - f0, 0);
    tx_pop("R11 retire oldest");
    for (int i = 0; i < 20 && n_frag == g0; i++) tick();
    chk(n_fifo == f0 + 1 && last_fifo == (32'h0000_8000 | (32'h77 << 2)), "R11 resumes",
        last_fifo, 32'h0000_8000 | (32'h77 << 2));
    eq[et % 32] = {1'b1, 8'h77}; et++;
    frag_done = 1'b1; tick(); frag_done = 1'b0;
    for (int i = 0; i < 60 && busy; i++) tick();
    chk(!busy, "R10 idle after stall", {31'd0, busy}, 0);
    for (int j = 0; j < 4; j++) tx_pop("R8 in-order retire");
    tx_pop("R11 drained");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule